// File: doc/BRIEF.md
# Calibration Trigger and Sequencer

This block decides when a converter's self-calibration runs. It watches a slow request pin with the sample clock. A request counts only when the pin has stayed low for a minimum number of consecutive cycles and then stayed high for the same minimum. The block also launches one calibration on its own after reset, once a power-up wait has passed. A select input chooses a short or a long wait, and there is a forced-short setting for boards where the select pin serves another purpose.

Each calibration appears as a one-cycle start strobe followed by a busy flag. The busy flag stays high for a fixed run length, which stands in for the calibration algorithm. A power-down input aborts any run in progress. While power-down is held, it also blocks the request logic and freezes the power-up wait. All pins are plain level controls and have no flow control.

Top module: `cal_sequencer_top`

## Requirements
- R1: While reset is asserted, `cal_busy` and `cal_start` are both 0.
- R2: With `dly_sel` = 2'b00, the automatic start strobe appears on clock edge SHORT_DLY+1 counted from the first edge after reset release.
- R3: With `dly_sel` = 2'b01, the automatic start appears on edge LONG_DLY+1 after reset release.
- R4: When `dly_sel[1]` = 1 (select pin repurposed), the short wait is used whatever `dly_sel[0]` is.
- R5: Suppose `cal_req` is sampled low on at least MIN_PHASE consecutive edges and then high on MIN_PHASE consecutive edges. Then `cal_start` rises on the edge after the one that samples the MIN_PHASE-th high.
- R6: If the low phase is shorter than MIN_PHASE edges, the following high phase is ignored however long it is.
- R7: If a high phase ends before MIN_PHASE edges, the earlier low phase is spent, and a fresh low phase of MIN_PHASE edges is needed.
- R8: `cal_start` is a one-cycle pulse in the first cycle of `cal_busy`. `cal_busy` then stays high for exactly RUN_LEN cycles unless the run is aborted.
- R9: Request activity while `cal_busy` is high has no effect. Low samples are counted only from the edge after `cal_busy` falls.
- R10: When `pwr_down` is 1, `cal_busy` is 0 after the next edge. No request is accepted while it is held, and the power-up wait does not advance.
- R11: Until the automatic power-up calibration has been launched, request patterns on `cal_req` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_req | input | 1 | Calibration request pin, level sampled |
| dly_sel | input | 2 | Power-up wait select: 00 short, 01 long, 1x forced short; held stable |
| pwr_down | input | 1 | Power-down: aborts and blocks calibration activity |
| cal_start | output | 1 | One-cycle strobe at the start of each calibration |
| cal_busy | output | 1 | High while a calibration run is active |

## Verification
The embedded assertions check the following on every cycle:
- the start strobe only ever opens a busy window and never fires inside one;
- busy ends only after the run counter drains or after a power-down;
- the power-up wait counter is frozen under power-down and fires at most once;
- a qualified request never follows a cycle in which the qualifier was cleared.

Three properties need the bench's scenarios: the exact start cycle for each request pattern and each wait setting, the rejection of short phases, and the rule that low samples taken during a busy window are never counted afterwards.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;

  typedef enum logic {
    RUN_IDLE = 1'b0,
    RUN_ACTIVE = 1'b1
  } run_state_e;

  // Wait select encoding: bit 1 forces the short wait, else bit 0 picks long.
  function automatic logic wants_long_wait(input logic [1:0] sel);
    return (sel[1] == 1'b0) && (sel[0] == 1'b1);
  endfunction

endpackage

// File: rtl/cal_req_qualifier.sv
module cal_req_qualifier #(
  parameter int MIN_PHASE = 80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic req,
  output logic trig
);

  localparam int PW = $clog2(MIN_PHASE + 1);
  localparam logic [PW-1:0] PH_FULL = PW'(MIN_PHASE);
  localparam logic [PW-1:0] PH_LAST = PW'(MIN_PHASE - 1);
  localparam logic [PW-1:0] PH_ONE  = PW'(1);

  logic [PW-1:0] lo_cnt;
  logic [PW-1:0] hi_cnt;
  logic          lo_ok;

  assign lo_ok = (lo_cnt == PH_FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt <= '0;
      hi_cnt <= '0;
      trig   <= 1'b0;
    end else if (clr) begin
      lo_cnt <= '0;
      hi_cnt <= '0;
      trig   <= 1'b0;
    end else begin
      trig <= 1'b0;
      if (!req) begin
        hi_cnt <= '0;
        if (hi_cnt != '0) begin
          // an unfinished high phase spends the earlier low phase
          lo_cnt <= PH_ONE;
        end else if (!lo_ok) begin
          lo_cnt <= lo_cnt + PH_ONE;
        end
      end else if (lo_ok) begin
        if (hi_cnt == PH_LAST) begin
          trig   <= 1'b1;
          lo_cnt <= '0;
          hi_cnt <= '0;
        end else begin
          hi_cnt <= hi_cnt + PH_ONE;
        end
      end else begin
        lo_cnt <= '0;
        hi_cnt <= '0;
      end
    end
  end

  // R5
  trig_after_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> $past(req));

  // R5
  trig_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !trig);

  // R9
  clr_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !trig);

endmodule

// File: rtl/cal_powerup_timer.sv
module cal_powerup_timer
  import cal_seq_pkg::*;
#(
  parameter int SHORT_DLY = 1 << 24,
  parameter int LONG_DLY  = 1 << 30
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hold,
  input  logic [1:0] dly_sel,
  output logic       fire,
  output logic       done
);

  localparam int MAX_DLY = (LONG_DLY > SHORT_DLY) ? LONG_DLY : SHORT_DLY;
  localparam int CW = $clog2(MAX_DLY + 1);
  localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_DLY - 1);
  localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_DLY - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;

  assign limit = wants_long_wait(dly_sel) ? LONG_LAST : SHORT_LAST;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      fire <= 1'b0;
      done <= 1'b0;
    end else begin
      fire <= 1'b0;
      if (!hold && !done) begin
        if (cnt >= limit) begin
          fire <= 1'b1;
          done <= 1'b1;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end

  // R2
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(done) |-> done);

  // R2
  fire_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> !$past(done));

  // R10
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> ($stable(cnt) && !fire));

endmodule

// File: rtl/cal_run_ctrl.sv
module cal_run_ctrl
  import cal_seq_pkg::*;
#(
  parameter int RUN_LEN = 1400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_down,
  input  logic auto_go,
  input  logic cmd_go,
  output logic cal_start,
  output logic busy
);

  localparam int RW = $clog2(RUN_LEN + 1);
  localparam logic [RW-1:0] RUN_LOAD = RW'(RUN_LEN - 1);

  run_state_e    st;
  logic [RW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= RUN_IDLE;
      run_cnt   <= '0;
      cal_start <= 1'b0;
    end else begin
      cal_start <= 1'b0;
      if (pwr_down) begin
        st      <= RUN_IDLE;
        run_cnt <= '0;
      end else begin
        case (st)
          RUN_IDLE: begin
            if (auto_go || cmd_go) begin
              st        <= RUN_ACTIVE;
              run_cnt   <= RUN_LOAD;
              cal_start <= 1'b1;
            end
          end
          RUN_ACTIVE: begin
            if (run_cnt == '0) begin
              st <= RUN_IDLE;
            end else begin
              run_cnt <= run_cnt - RW'(1);
            end
          end
          default: st <= RUN_IDLE;
        endcase
      end
    end
  end

  assign busy = (st == RUN_ACTIVE);

  // R8
  start_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |-> busy);

  // R8
  start_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |-> !$past(busy));

  // R8
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(pwr_down) || ($past(run_cnt) == '0)));

  // R10
  pd_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> !busy);

endmodule

// File: rtl/cal_sequencer_top.sv
module cal_sequencer_top #(
  parameter int MIN_PHASE = 80,
  parameter int SHORT_DLY = 1 << 24,
  parameter int LONG_DLY  = 1 << 30,
  parameter int RUN_LEN   = 1400
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cal_req,
  input  logic [1:0] dly_sel,
  input  logic       pwr_down,
  output logic       cal_start,
  output logic       cal_busy
);

  logic boot_fire;
  logic boot_done;
  logic cmd_trig;
  logic qual_clr;

  // Requests are held off until the boot run is launched, during runs and in power-down.
  assign qual_clr = cal_busy | pwr_down | ~boot_done;

  cal_powerup_timer #(
    .SHORT_DLY(SHORT_DLY),
    .LONG_DLY (LONG_DLY)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .hold   (pwr_down),
    .dly_sel(dly_sel),
    .fire   (boot_fire),
    .done   (boot_done)
  );

  cal_req_qualifier #(
    .MIN_PHASE(MIN_PHASE)
  ) u_qual (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (qual_clr),
    .req  (cal_req),
    .trig (cmd_trig)
  );

  cal_run_ctrl #(
    .RUN_LEN(RUN_LEN)
  ) u_run (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_down (pwr_down),
    .auto_go  (boot_fire),
    .cmd_go   (cmd_trig),
    .cal_start(cal_start),
    .busy     (cal_busy)
  );

  // R11
  no_cmd_before_boot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_done |=> !cmd_trig);

endmodule

// File: tb/cal_sequencer_top_tb_top.sv
module cal_sequencer_top_tb_top;

  localparam int MINP  = 80;
  localparam int SHORT = 300;
  localparam int LONG  = 900;
  localparam int RUN   = 200;

  typedef struct {
    int    cyc;
    string tag;
  } exp_item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cal_req = 1'b1;
  logic [1:0] dly_sel = 2'b00;
  logic       pwr_down = 1'b0;
  logic       cal_start;
  logic       cal_busy;

  int        cyc = 0;
  int        n_chk = 0;
  int        n_fail = 0;
  int        blen = 0;
  bit        abort_pend = 1'b0;
  bit        finished = 1'b0;
  exp_item_t exp_q[$];

  always #10 clk = ~clk;

  cal_sequencer_top #(
    .MIN_PHASE(MINP),
    .SHORT_DLY(SHORT),
    .LONG_DLY (LONG),
    .RUN_LEN  (RUN)
  ) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cal_req  (cal_req),
    .dly_sel  (dly_sel),
    .pwr_down (pwr_down),
    .cal_start(cal_start),
    .cal_busy (cal_busy)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic push_exp(input int c, input string tag);
    exp_item_t it;
    it.cyc = c;
    it.tag = tag;
    exp_q.push_back(it);
  endtask

  always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

  // Monitor: compares each start strobe with the scoreboard and measures busy runs.
  always @(negedge clk) begin
    if (!rst_n) begin
      blen = 0;
    end else begin
      if (cal_start) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R6/R7/R9/R10/R11 unexpected start", cyc, -1);
        end else begin
          exp_item_t it;
          it = exp_q.pop_front();
          check(cyc == it.cyc, it.tag, cyc, it.cyc);
        end
      end
      if (cal_busy) begin
        blen++;
      end else if (blen != 0) begin
        if (!abort_pend) check(blen == RUN, "R8 busy length", blen, RUN);
        abort_pend = 1'b0;
        blen = 0;
      end
    end
  end

  task automatic do_reset(input logic [1:0] sel, input int exp_cyc, input string tag);
    @(negedge clk);
    rst_n = 1'b0;
    dly_sel = sel;
    cal_req = 1'b1;
    pwr_down = 1'b0;
    abort_pend = 1'b0;
    repeat (3) @(negedge clk);
    check(cal_busy == 1'b0, "R1 busy in reset", cal_busy, 0);
    check(cal_start == 1'b0, "R1 start in reset", cal_start, 0);
    push_exp(exp_cyc, tag);
    rst_n = 1'b1;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (exp_q.size() != 0 || cal_busy);
  endtask

  task automatic req_pattern(input int lo, input int hi, input bit expect_go, input string tag);
    cal_req = 1'b0;
    repeat (lo) @(negedge clk);
    cal_req = 1'b1;
    if (expect_go) push_exp(cyc + MINP + 1, tag);
    repeat (hi) @(negedge clk);
  endtask

  initial begin
    // R1, R2, R11: short boot wait, with a request pattern during the wait
    do_reset(2'b00, SHORT + 1, "R2 short boot start");
    @(negedge clk);
    req_pattern(MINP, MINP, 1'b0, "R11");
    wait_idle();

    // R5: minimum phases, then a long low phase
    @(negedge clk);
    req_pattern(MINP, MINP, 1'b1, "R5 minimal request");
    wait_idle();
    req_pattern(200, MINP, 1'b1, "R5 long low request");
    wait_idle();

    // R6: low phase one short
    req_pattern(MINP - 1, 120, 1'b0, "R6");
    // R7: high phase one short, then a short low, then high
    req_pattern(MINP, MINP - 1, 1'b0, "R7");
    req_pattern(30, 90, 1'b0, "R7");
    req_pattern(MINP, MINP, 1'b1, "R7 fresh low accepted");
    wait_idle();

    // R9: a full pattern inside the busy window is ignored
    req_pattern(MINP, MINP, 1'b1, "R9 start before busy");
    req_pattern(MINP, MINP, 1'b0, "R9");
    wait_idle();
    // R9: low phase straddling the busy fall counts only after it
    req_pattern(MINP, MINP, 1'b1, "R9 second start");
    cal_req = 1'b0;
    do @(negedge clk); while (!cal_busy);
    do @(negedge clk); while (cal_busy);
    repeat (40) @(negedge clk);
    cal_req = 1'b1;
    repeat (100) @(negedge clk);
    check(cal_busy == 1'b0, "R9 straddled low rejected", cal_busy, 0);

    // R10: abort a run, then a pattern under power-down
    req_pattern(MINP, MINP, 1'b1, "R10 run to abort");
    do @(negedge clk); while (!cal_busy);
    repeat (20) @(negedge clk);
    abort_pend = 1'b1;
    pwr_down = 1'b1;
    @(negedge clk);
    check(cal_busy == 1'b0, "R10 busy after power-down", cal_busy, 0);
    req_pattern(MINP, 100, 1'b0, "R10");
    pwr_down = 1'b0;
    repeat (10) @(negedge clk);
    check(cal_busy == 1'b0, "R10 no start after power-down", cal_busy, 0);

    // R4, R10: forced short wait, frozen for 50 edges
    do_reset(2'b10, SHORT + 1 + 50, "R10 frozen boot wait");
    repeat (100) @(negedge clk);
    pwr_down = 1'b1;
    repeat (50) @(negedge clk);
    pwr_down = 1'b0;
    wait_idle();
    do_reset(2'b11, SHORT + 1, "R4 forced short boot start");
    wait_idle();

    // R3: long boot wait
    do_reset(2'b01, LONG + 1, "R3 long boot start");
    wait_idle();

    repeat (50) @(negedge clk);
    check(exp_q.size() == 0, "R5 all expected starts seen", exp_q.size(), 0);
    finished = 1'b1;
  end

  initial begin
    fork
      begin
        wait (finished);
      end
      begin
        repeat (200000) @(posedge clk);
        check(1'b0, "R1 watchdog expired", 0, 1);
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule